// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one timer channel working as an input capture. An asynchronous channel pin is brought into the module clock domain and passed through a programmable digital glitch filter. It then reaches an edge detector. When an edge of the selected polarity is accepted, the value on the free-running counter input is stored in a capture register, and a sticky flag is raised. Software clears the flag with a single-cycle write-one-to-clear pulse.

The filter length is four times a 4-bit filter value, counted in filter-clock ticks. A filter value of zero bypasses the filter. The filter clock is a one-cycle enable from a free-running divider inside the block. A prescaler value of zero makes every module clock a tick, and a value p divides by p+1. The latency from a pin edge to the flag is fixed by these two settings. This lets software correct the captured time stamp by a known amount.

Top module: `filt_capture_chan`

## Requirements
- R1: While reset is asserted and after it is released with no input activity, `flag_o` is 0 and `cap_o` is 0.
- R2: With filter value 0 and prescaler 0, `flag_o` rises on the 3rd module clock rising edge after a selected edge on `chan_i`.
- R3: With filter value 0 and prescaler p (nonzero), the divider ticks on the k-th rising edge after reset release whenever k is a multiple of p+1. `flag_o` rises on the first such tick edge that is the 3rd or a later edge after the input edge.
- R4: With filter value N (nonzero) and prescaler 0, `flag_o` rises on rising edge 4+4N after the input edge. For N=2 this is edge 12.
- R5: With filter value N and prescaler p (both nonzero), `flag_o` rises on the (1+4N)-th tick edge, counting only tick edges that are the 4th or a later edge after the input edge.
- R6: On the edge where the flag is set, `cap_o` takes the value that `cnt_i` holds at that edge. This is not the value at the time of the pin edge.
- R7: `edge_sel_i` encoding: 2'b00 gives no capture, 2'b01 rising only, 2'b10 falling only, 2'b11 both edges. An edge of a polarity that is not selected changes neither output.
- R8: The filter accepts a new level only after the synchronized input has held it for the full window. If the input returns to the accepted level before that, it produces no capture, and a later change starts a fresh window.
- R9: `flag_o` stays 1 until `clr_i` is 1 on a rising edge, and then reads 0 after that edge.
- R10: If a capture and `clr_i` occur on the same edge, `flag_o` is 1 after that edge.
- R11: `cap_o` holds its value on every edge without a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_i | input | 1 | Asynchronous channel pin |
| cnt_i | input | CNT_W | Free-running counter value |
| fval_i | input | FVAL_W | Filter value, 0 bypasses the filter |
| psc_i | input | PSC_W | Filter clock prescaler, divide by value+1 |
| edge_sel_i | input | 2 | Edge select: 00 none, 01 rise, 10 fall, 11 both |
| clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| flag_o | output | 1 | Sticky capture flag |
| cap_o | output | CNT_W | Captured counter value |

## Verification
The capture path is tried with four kinds of setting: filter off or on, crossed with a prescaler of zero or nonzero. Each case is checked one edge before and exactly at the predicted flag edge. This separates a missing synchronizer stage, a miscounted window and a divider phase error. Rising, falling and both-edge selections are tried with each pin polarity, and the none selection is tried too. This shows whether the polarity decode is swapped. A short glitch, and a pulse cut by a one-cycle dip, show whether the window restarts on a return to the accepted level. The counter input is a scaled copy of the cycle count, so a capture one cycle off gives a different stored value.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/fcap_tick_gen.sv
module fcap_tick_gen #(
  parameter int PSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  assign tick_o = (psc_i == '0) || (div_q == psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/fcap_sync.sv
module fcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o,
  output logic dly_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
  // one more stage, used in front of the enabled filter
  assign dly_o  = chain_q[STAGES];
endmodule

// File: rtl/fcap_filter.sv
module fcap_filter #(
  parameter int FVAL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              tick_i,
  input  logic [FVAL_W-1:0] fval_i,
  output logic              lvl_o,
  output logic              acc_o
);
  localparam int FCNT_W = FVAL_W + 2;

  logic [FCNT_W-1:0] cnt_q;
  logic [FCNT_W-1:0] target;
  logic              lvl_q;
  logic              differ;

  assign target = {fval_i, 2'b00};
  assign differ = src_i != lvl_q;
  assign acc_o  = differ && tick_i && (cnt_q == target);
  assign lvl_o  = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (acc_o) begin
      cnt_q <= '0;
      lvl_q <= src_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fcap_capture.sv
module fcap_capture
  import fcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             new_lvl_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic             cap_evt_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cap_o
);
  edge_sel_e sel;
  logic      match;

  assign sel = edge_sel_e'(edge_sel_i);

  always_comb begin
    unique case (sel)
      EDGE_RISE: match = new_lvl_i;
      EDGE_FALL: match = !new_lvl_i;
      EDGE_BOTH: match = 1'b1;
      default:   match = 1'b0;
    endcase
  end

  assign cap_evt_o = acc_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cap_o  <= '0;
    end else begin
      if (cap_evt_o) begin
        flag_o <= 1'b1;
        cap_o  <= cnt_i;
      end else if (clr_i) begin
        flag_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/filt_capture_chan.sv
module filt_capture_chan #(
  parameter int CNT_W  = 16,
  parameter int FVAL_W = 4,
  parameter int PSC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FVAL_W-1:0] fval_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [CNT_W-1:0]  cap_o
);
  logic tick;
  logic sync_lvl;
  logic dly_lvl;
  logic flt_src;
  logic flt_lvl;
  logic acc;
  logic cap_evt;

  fcap_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .psc_i  (psc_i),
    .tick_o (tick)
  );

  fcap_sync #(.STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (chan_i),
    .sync_o  (sync_lvl),
    .dly_o   (dly_lvl)
  );

  // the bypass path skips the extra stage, which keeps the latency at 3 edges
  assign flt_src = (fval_i != '0) ? dly_lvl : sync_lvl;

  fcap_filter #(.FVAL_W(FVAL_W)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (flt_src),
    .tick_i (tick),
    .fval_i (fval_i),
    .lvl_o  (flt_lvl),
    .acc_o  (acc)
  );

  fcap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .new_lvl_i  (flt_src),
    .edge_sel_i (edge_sel_i),
    .cnt_i      (cnt_i),
    .clr_i      (clr_i),
    .cap_evt_o  (cap_evt),
    .flag_o     (flag_o),
    .cap_o      (cap_o)
  );
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [1:0]       edge_sel_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             flag_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             cap_evt_i,
  input logic             acc_i,
  input logic             flt_lvl_i
);
  AST_CAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> flag_o); // R10
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_evt_i) |=> !flag_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R9
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !cap_evt_i) |=> !flag_o); // R9
  AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (cap_o == $past(cnt_i))); // R6
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt_i |=> $stable(cap_o)); // R11
  AST_SEL_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b00) |-> !cap_evt_i); // R7
  AST_LVL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(flt_lvl_i)); // R8
endmodule

bind filt_capture_chan fcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .edge_sel_i (edge_sel_i),
  .cnt_i      (cnt_i),
  .flag_o     (flag_o),
  .cap_o      (cap_o),
  .cap_evt_i  (cap_evt),
  .acc_i      (acc),
  .flt_lvl_i  (flt_lvl)
);

// File: tb/filt_capture_chan_test.sv
`timescale 1ns/1ps
module filt_capture_chan_test;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [3:0] fv;
    logic [3:0] ps;
    logic [1:0] sel;
    logic       rise;
    logic       exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  4'd0, 2'b01, 1'b1, 1'b1},  // R2
    '{4'd0,  4'd3, 2'b01, 1'b1, 1'b1},  // R3
    '{4'd2,  4'd0, 2'b01, 1'b1, 1'b1},  // R4
    '{4'd1,  4'd2, 2'b01, 1'b1, 1'b1},  // R5
    '{4'd3,  4'd0, 2'b10, 1'b0, 1'b1},  // R7 fall only
    '{4'd1,  4'd0, 2'b10, 1'b1, 1'b0},  // R7 rise ignored
    '{4'd0,  4'd0, 2'b11, 1'b0, 1'b1},  // R7 both
    '{4'd0,  4'd0, 2'b00, 1'b1, 1'b0},  // R7 none
    '{4'd2,  4'd1, 2'b11, 1'b1, 1'b1},  // R5
    '{4'd15, 4'd0, 2'b01, 1'b1, 1'b1}   // R4 longest window
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             chan = 1'b0;
  logic [3:0]       fval = '0;
  logic [3:0]       psc = '0;
  logic [1:0]       sel = 2'b01;
  logic             clr = 1'b0;
  logic             flag;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] cnt;
  int               ecnt;
  int               checks = 0;
  int               fails = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  function automatic logic [CNT_W-1:0] cval(int e);
    return CNT_W'(e * 7 + 3);
  endfunction

  assign cnt = cval(ecnt);

  filt_capture_chan #(.CNT_W(CNT_W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .chan_i     (chan),
    .cnt_i      (cnt),
    .fval_i     (fval),
    .psc_i      (psc),
    .edge_sel_i (sel),
    .clr_i      (clr),
    .flag_o     (flag),
    .cap_o      (cap)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // absolute edge index on which the flag is expected to rise
  function automatic int exp_edge(int a, int n, int p);
    int first = (n == 0) ? 3 : 4;
    int need  = 4 * n + 1;
    int t = 0;
    for (int k = 1; k < 5000; k++) begin
      if (k >= first && ((a + k) % (p + 1)) == 0) begin
        t++;
        if (t == need) return a + k;
      end
    end
    return -1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic wait_to(int e);
    while (ecnt < e) @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a, e;
    logic [CNT_W-1:0] prev;
    string tag;

    // R1 reset state
    rst_n = 1'b0;
    #7;
    chk("R1", flag, 0);
    chk("R1", cap, 0);
    do_reset();
    repeat (10) @(negedge clk);
    chk("R1", flag, 0);
    chk("R1", cap, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      fval = v.fv;
      psc  = v.ps;
      sel  = v.sel;
      chan = !v.rise;
      do_reset();
      if (!v.rise) begin
        repeat (1100) @(negedge clk);
        pulse_clr();
      end
      repeat (4) @(negedge clk);
      prev = cap;
      a = ecnt;
      chan = v.rise;
      e = exp_edge(a, v.fv, v.ps);
      if (v.sel != 2'b01 || !v.rise) tag = "R7";
      else if (v.fv == 0) tag = (v.ps == 0) ? "R2" : "R3";
      else tag = (v.ps == 0) ? "R4" : "R5";
      wait_to(e - 1);
      chk(tag, flag, 0);
      @(negedge clk);
      chk(tag, flag, v.exp);
      if (v.exp) chk("R6", cap, cval(e - 1));
      else       chk("R11", cap, prev);
    end

    // R8 short glitch never captures
    fval = 4'd2; psc = 4'd0; sel = 2'b11; chan = 1'b0;
    do_reset();
    repeat (4) @(negedge clk);
    chan = 1'b1;
    repeat (6) @(negedge clk);
    chan = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8", flag, 0);
    chk("R8", cap, 0);

    // R8 a one-cycle dip restarts the window
    chan = 1'b1;
    repeat (8) @(negedge clk);
    chan = 1'b0;
    @(negedge clk);
    a = ecnt;
    chan = 1'b1;
    e = exp_edge(a, 2, 0);
    wait_to(e - 1);
    chk("R8", flag, 0);
    @(negedge clk);
    chk("R8", flag, 1);
    chk("R6", cap, cval(e - 1));

    // R9 flag holds, then clears
    repeat (20) @(negedge clk);
    chk("R9", flag, 1);
    pulse_clr();
    chk("R9", flag, 0);
    chk("R11", cap, cval(e - 1));

    // R10 capture and clear on the same edge
    fval = 4'd0; psc = 4'd0; sel = 2'b10;
    a = ecnt;
    chan = 1'b0;
    e = exp_edge(a, 0, 0);
    wait_to(e - 1);
    chk("R10", flag, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10", flag, 1);
    chk("R6", cap, cval(e - 1));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule